// File: doc/BRIEF.md
# Multi-Mode Column Driver Data Loader

This block stages digital video for a 192-column display driver. Pixel bits arrive on a 6-bit bus, paced by a shift clock, and collect in a 192-bit column register. A falling edge on an active-low strobe copies the column register into an output latch. The latch drives the 192 column bits and keeps them until the next falling strobe edge, so the next line can load while the current one is shown.

A 2-bit configuration input sets how the bus is split:
- six lanes of 32 samples;
- three lanes of 64 samples;
- three lanes sampled on both shift-clock edges (64 samples in 32 clock periods);
- two groups of three lanes, each filling one half of the columns.

A direction input sets whether the first samples land on the low-numbered or the high-numbered columns. In the dual-edge mode the bus carries already-resolved single-ended bits on its three low lanes.

The shift clock and strobe are sampled by a faster system clock `clk`. The block finds their edges in that clock domain, and all state sits in one synchronous domain with an active-high reset.

Top module: `coldrv_loader`

## Requirements
- R1: A synchronous active-high `rst` clears the column register and `dout` to all zeros.
- R2: `bus_cfg` selects the mode: 2'b00 gives six lanes x 32 samples, 2'b01 gives three lanes x 64, 2'b10 gives dual-edge three lanes x 64 samples, and 2'b11 gives two groups of three lanes x 32. Lane n is `din[n]`.
- R3: In the six-lane mode, sample k (counted from 0) with `dir`=0 places lane n on column index 6k+n. With `dir`=1 it places lane n on 6(31-k)+n, so the first sample reaches indices 186..191.
- R4: In the three-lane mode, sample k places lane n on index 3k+n when `dir`=0 and on 3(63-k)+n when `dir`=1, so the first lane-0 bit reaches index 189. `din[5:3]` has no effect.
- R5: In the dual-edge mode, both rising and falling `sclk` edges take a sample, and 32 clock periods fill all 192 columns. Placement follows the R4 formulas, so the first falling-edge lane-0 bit lands on index 3 when `dir`=0. `din[5:3]` has no effect.
- R6: In the split mode, lanes 0..2 fill indices 0..95 and lanes 3..5 fill 96..191. Within each half, sample k places local lane j at 3k+j when `dir`=0 and at 3(31-k)+j when `dir`=1.
- R7: `dout` changes only after a falling edge of `stb_n`, when it takes the column register content. Further shifting leaves `dout` unchanged.
- R8: A falling strobe edge restarts the load, and `bus_cfg` and `dir` are taken at the first sample of each load.
- R9: After a full load, the next sample starts a new load at sample position 0.
- R10: In the single-edge modes only rising `sclk` edges take samples. Data present at falling edges has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Shift clock, edge-detected in `clk` domain |
| stb_n | input | 1 | Active-low strobe; falling edge latches |
| bus_cfg | input | 2 | Bus configuration select |
| dir | input | 1 | Fill direction |
| din | input | 6 | Input data lanes |
| dout | output | 192 | Latched column bits |

## Verification
The hardest case to reach from the ports is a sample taken on a falling `sclk` edge. The same stimulus must also show that a falling edge is ignored in every other mode. The bench drives `sclk` as slow data, holding each level for several system clocks. It sends different data on the rising and falling halves of every period, so each mode has a falling-edge value that must either land (dual-edge) or vanish (single-edge). A second hard case is the load boundary: wrap after a full load and restart on a mid-load strobe. Single-hot loads cover it, putting one set bit at sample 32 or after a partial load. The expected position is then a literal index taken from the requirements.

// File: rtl/coldrv_pkg.sv
package coldrv_pkg;
  typedef enum logic [1:0] {
    CFG_WIDE   = 2'b00,
    CFG_NARROW = 2'b01,
    CFG_DUAL   = 2'b10,
    CFG_SPLIT  = 2'b11
  } bus_cfg_e;
endpackage

// File: rtl/coldrv_in_stage.sv
module coldrv_in_stage #(
  parameter int BUS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             stb_n,
  input  logic [1:0]       bus_cfg,
  input  logic             dir,
  input  logic [BUS_W-1:0] din,
  output logic             sclk_rise,
  output logic             sclk_fall,
  output logic             stb_fall,
  output logic [1:0]       cfg_q,
  output logic             dir_q,
  output logic [BUS_W-1:0] din_q
);
  logic sclk_q, sclk_d, stb_q, stb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      sclk_d <= 1'b0;
      stb_q  <= 1'b1;
      stb_d  <= 1'b1;
      cfg_q  <= '0;
      dir_q  <= 1'b0;
      din_q  <= '0;
    end else begin
      sclk_q <= sclk;
      sclk_d <= sclk_q;
      stb_q  <= stb_n;
      stb_d  <= stb_q;
      cfg_q  <= bus_cfg;
      dir_q  <= dir;
      din_q  <= din;
    end
  end

  assign sclk_rise = sclk_q & ~sclk_d;
  assign sclk_fall = ~sclk_q & sclk_d;
  assign stb_fall  = ~stb_q & stb_d;
endmodule

// File: rtl/coldrv_fill_ctrl.sv
module coldrv_fill_ctrl
  import coldrv_pkg::*;
#(
  parameter int NUM_OUT  = 192,
  parameter int BUS_W    = 6,
  parameter int NARROW_W = 3,
  localparam int WIDE_D   = NUM_OUT / BUS_W,
  localparam int NARROW_D = NUM_OUT / NARROW_W,
  localparam int SPLIT_D  = NUM_OUT / (2 * NARROW_W),
  localparam int CNT_W    = $clog2(NARROW_D)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rise,
  input  logic           fall,
  input  logic           restart,
  input  logic [1:0]     cfg_in,
  input  logic           dir_in,
  output logic           wr_en,
  output bus_cfg_e       cfg_cur,
  output logic [CNT_W-1:0] step,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W:0]   depth
);
  bus_cfg_e   cfg_hold;
  logic       dir_hold, dir_cur, last;
  logic [CNT_W:0] rev;

  always_comb begin
    cfg_cur = (cnt == '0) ? bus_cfg_e'(cfg_in) : cfg_hold;
    dir_cur = (cnt == '0) ? dir_in : dir_hold;
    unique case (cfg_cur)
      CFG_WIDE:   depth = (CNT_W+1)'(WIDE_D);
      CFG_NARROW: depth = (CNT_W+1)'(NARROW_D);
      CFG_DUAL:   depth = (CNT_W+1)'(NARROW_D);
      default:    depth = (CNT_W+1)'(SPLIT_D);
    endcase
    wr_en = rise | (fall & (cfg_cur == CFG_DUAL));
    last  = ({1'b0, cnt} == depth - 1'b1);
    rev   = depth - 1'b1 - {1'b0, cnt};
    step  = dir_cur ? rev[CNT_W-1:0] : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cfg_hold <= CFG_WIDE;
      dir_hold <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
    end else if (wr_en) begin
      if (cnt == '0) begin
        cfg_hold <= cfg_cur;
        dir_hold <= dir_cur;
      end
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/coldrv_col_reg.sv
module coldrv_col_reg
  import coldrv_pkg::*;
#(
  parameter int NUM_OUT  = 192,
  parameter int BUS_W    = 6,
  parameter int NARROW_W = 3,
  parameter int CNT_W    = 6,
  localparam int IDX_W     = $clog2(NUM_OUT),
  localparam int POS_W     = IDX_W + 2,
  localparam int SPLIT_GAP = NUM_OUT / 2 - NARROW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  bus_cfg_e           cfg,
  input  logic [CNT_W-1:0]   step,
  input  logic [BUS_W-1:0]   din,
  output logic [NUM_OUT-1:0] col_q
);
  logic [BUS_W-1:0][IDX_W-1:0] lane_idx;
  logic [BUS_W-1:0]            lane_on;

  always_comb begin
    logic [POS_W-1:0] grp, off, pos;
    logic             all_lanes;
    grp       = (cfg == CFG_WIDE) ? POS_W'(BUS_W) : POS_W'(NARROW_W);
    all_lanes = (cfg == CFG_WIDE) || (cfg == CFG_SPLIT);
    for (int l = 0; l < BUS_W; l++) begin
      off = POS_W'(l);
      if (cfg == CFG_SPLIT && l >= NARROW_W) off = off + POS_W'(SPLIT_GAP);
      pos = POS_W'(step) * grp + off;
      lane_on[l]  = wr_en && (all_lanes || l < NARROW_W) && (pos < POS_W'(NUM_OUT));
      lane_idx[l] = pos[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
    end else begin
      for (int l = 0; l < BUS_W; l++) begin
        if (lane_on[l]) col_q[lane_idx[l]] <= din[l];
      end
    end
  end
endmodule

// File: rtl/coldrv_out_latch.sv
module coldrv_out_latch #(
  parameter int NUM_OUT = 192
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic [NUM_OUT-1:0] col,
  output logic [NUM_OUT-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (capture) dout <= col;
  end
endmodule

// File: rtl/coldrv_loader.sv
module coldrv_loader
  import coldrv_pkg::*;
#(
  parameter int NUM_OUT  = 192,
  parameter int BUS_W    = 6,
  parameter int NARROW_W = 3,
  localparam int CNT_W   = $clog2(NUM_OUT / NARROW_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               stb_n,
  input  logic [1:0]         bus_cfg,
  input  logic               dir,
  input  logic [BUS_W-1:0]   din,
  output logic [NUM_OUT-1:0] dout
);
  logic               sclk_rise, sclk_fall, stb_fall, dir_q, wr_en;
  logic [1:0]         cfg_q;
  logic [BUS_W-1:0]   din_q;
  bus_cfg_e           cfg_cur;
  logic [CNT_W-1:0]   step, fill_cnt;
  logic [CNT_W:0]     fill_depth;
  logic [NUM_OUT-1:0] col_q;

  coldrv_in_stage #(.BUS_W(BUS_W)) in_i (
    .clk(clk), .rst(rst), .sclk(sclk), .stb_n(stb_n), .bus_cfg(bus_cfg),
    .dir(dir), .din(din), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .stb_fall(stb_fall), .cfg_q(cfg_q), .dir_q(dir_q), .din_q(din_q)
  );

  coldrv_fill_ctrl #(.NUM_OUT(NUM_OUT), .BUS_W(BUS_W), .NARROW_W(NARROW_W)) ctrl_i (
    .clk(clk), .rst(rst), .rise(sclk_rise), .fall(sclk_fall), .restart(stb_fall),
    .cfg_in(cfg_q), .dir_in(dir_q), .wr_en(wr_en), .cfg_cur(cfg_cur),
    .step(step), .cnt(fill_cnt), .depth(fill_depth)
  );

  coldrv_col_reg #(.NUM_OUT(NUM_OUT), .BUS_W(BUS_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) col_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cfg(cfg_cur), .step(step),
    .din(din_q), .col_q(col_q)
  );

  coldrv_out_latch #(.NUM_OUT(NUM_OUT)) lat_i (
    .clk(clk), .rst(rst), .capture(stb_fall), .col(col_q), .dout(dout)
  );
endmodule

// File: rtl/coldrv_loader_chk.sv
module coldrv_loader_chk #(
  parameter int NUM_OUT = 192,
  parameter int CNT_W   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               stb_fall,
  input logic [NUM_OUT-1:0] col_q,
  input logic [NUM_OUT-1:0] dout,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W:0]     depth
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b0)
      AST_RST_CLEAR: assert (dout == '0 && col_q == '0); // R1
  end

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
    stb_fall |=> (dout == $past(col_q))); // R7

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb_fall |=> $stable(dout)); // R7

  AST_STB_RESTART: assert property (@(posedge clk) disable iff (rst)
    stb_fall |=> (cnt == '0)); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} < depth)); // R9
endmodule

bind coldrv_loader coldrv_loader_chk #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .stb_fall(stb_fall), .col_q(col_q), .dout(dout),
  .cnt(fill_cnt), .depth(fill_depth)
);

// File: tb/coldrv_loader_tb.sv
module coldrv_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 192;

  // {cfg[15:14], dir[13], seed[12:8], index of first lane-0 bit[7:0]}
  localparam logic [15:0] VECS [8] = '{
    {2'b00, 1'b0, 5'd3,  8'd0},
    {2'b00, 1'b1, 5'd4,  8'd186},
    {2'b01, 1'b0, 5'd7,  8'd0},
    {2'b01, 1'b1, 5'd8,  8'd189},
    {2'b10, 1'b0, 5'd11, 8'd0},
    {2'b10, 1'b1, 5'd12, 8'd189},
    {2'b11, 1'b0, 5'd15, 8'd0},
    {2'b11, 1'b1, 5'd16, 8'd93}
  };

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, stb_n = 1'b1, dir_drv = 1'b0;
  logic [1:0] cfg_drv = 2'b00;
  logic [5:0] din = '0;
  logic [N-1:0] dout;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] exp_col = '0, exp_dout = '0;
  int m_cnt = 0;
  logic [1:0] m_cfg = 2'b00;
  logic m_dir = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coldrv_loader dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .stb_n(stb_n), .bus_cfg(cfg_drv),
    .dir(dir_drv), .din(din), .dout(dout)
  );

  function automatic int depth_of(input logic [1:0] c);
    return (c == 2'b01 || c == 2'b10) ? 64 : 32;
  endfunction

  function automatic logic [5:0] gen(input int seed, input int i);
    return 6'(i * 37 + seed * 11 + (i >> 2) * 5 + 1) ^ 6'(seed);
  endfunction

  // Reference placement from R3..R6, R9
  task automatic model_sample(input logic [5:0] d);
    logic [1:0] c; logic dr; int dep, g, lanes, st, pos;
    c  = (m_cnt == 0) ? cfg_drv : m_cfg;
    dr = (m_cnt == 0) ? dir_drv : m_dir;
    if (m_cnt == 0) begin m_cfg = c; m_dir = dr; end
    dep   = depth_of(c);
    g     = (c == 2'b00) ? 6 : 3;
    lanes = (c == 2'b00 || c == 2'b11) ? 6 : 3;
    st    = dr ? dep - 1 - m_cnt : m_cnt;
    for (int l = 0; l < lanes; l++) begin
      pos = st * g + l + ((c == 2'b11 && l >= 3) ? 93 : 0);
      exp_col[pos] = d[l];
    end
    m_cnt = (m_cnt == dep - 1) ? 0 : m_cnt + 1;
  endtask

  task automatic drive_edge(input logic lvl, input logic [5:0] d);
    logic c;
    din = d;
    @(negedge clk);
    c = (m_cnt == 0) ? (cfg_drv == 2'b10) : (m_cfg == 2'b10);
    if ((lvl && !sclk) || (!lvl && sclk && c)) model_sample(d);
    sclk = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); stb_n = 1'b0;
    repeat (3) @(negedge clk); stb_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_dout = exp_col;
    m_cnt = 0;
  endtask

  // n samples; R10: single-edge falls carry different data that must be ignored
  task automatic full_load(input int seed, input int n);
    if (cfg_drv == 2'b10) begin
      for (int i = 0; i < n / 2; i++) begin
        drive_edge(1'b1, gen(seed, 2 * i));
        drive_edge(1'b0, gen(seed, 2 * i + 1));
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        drive_edge(1'b1, gen(seed, i));
        drive_edge(1'b0, gen(seed, i + 100));
      end
    end
  endtask

  task automatic sparse_load(input int n, input int hot, input logic [5:0] hv);
    if (cfg_drv == 2'b10) begin
      for (int i = 0; i < n; i++) drive_edge(i[0] ? 1'b0 : 1'b1, (i == hot) ? hv : 6'h00);
      if (n[0]) drive_edge(1'b0, 6'h00);
    end else begin
      for (int i = 0; i < n; i++) begin
        drive_edge(1'b1, (i == hot) ? hv : 6'h00);
        drive_edge(1'b0, 6'h3F);
      end
    end
  endtask

  task automatic check_vec(input string tag, input logic [N-1:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, dout, exp);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_vec("R1 reset state", '0);

    // Table walk: R2 with R3/R4/R5/R6 per mode, R10 via ignored falling data
    foreach (VECS[v]) begin
      logic [15:0] e; string tag; logic [5:0] first;
      e = VECS[v];
      cfg_drv = e[15:14]; dir_drv = e[13];
      strobe();
      full_load(int'(e[12:8]), depth_of(e[15:14]));
      strobe();
      case (e[15:14])
        2'b00: tag = "R2 R3 R10 six-lane";
        2'b01: tag = "R2 R4 R10 three-lane";
        2'b10: tag = "R2 R5 dual-edge";
        default: tag = "R2 R6 R10 split";
      endcase
      check_vec(tag, exp_dout);
      first = gen(int'(e[12:8]), 0);
      checks++;
      if (dout[e[7:0]] !== first[0]) begin
        errors++;
        $display("FAIL %s first bit idx %0d: actual %b expected %b", tag, e[7:0], dout[e[7:0]], first[0]);
      end
    end

    // R3 literal: last sample lane 5, dir=0 -> index 191
    cfg_drv = 2'b00; dir_drv = 1'b0;
    sparse_load(32, 31, 6'b100000); strobe();
    check_vec("R3 last lane5 to 191", {1'b1, 191'b0});

    // R4: upper lanes ignored in three-lane mode
    cfg_drv = 2'b01; dir_drv = 1'b1;
    sparse_load(64, 0, 6'b111000); strobe();
    check_vec("R4 din[5:3] ignored", '0);
    sparse_load(64, 0, 6'b000001); strobe();
    check_vec("R4 dir=1 first bit to 189", (192'b1 << 189));

    // R5: falling-edge sample 1, dir=0 -> index 3
    cfg_drv = 2'b10; dir_drv = 1'b0;
    sparse_load(64, 1, 6'b000001); strobe();
    check_vec("R5 falling sample to 3", (192'b1 << 3));

    // R6: lane 3 first group-two column
    cfg_drv = 2'b11; dir_drv = 1'b0;
    sparse_load(32, 0, 6'b001000); strobe();
    check_vec("R6 lane3 dir0 to 96", (192'b1 << 96));
    dir_drv = 1'b1;
    sparse_load(32, 0, 6'b001000); strobe();
    check_vec("R6 lane3 dir1 to 189", (192'b1 << 189));

    // R7: shifting a new line leaves the latch unchanged
    cfg_drv = 2'b00; dir_drv = 1'b0;
    full_load(21, 32); strobe();
    check_vec("R7 latched line", exp_dout);
    full_load(22, 32);
    check_vec("R7 hold while shifting", exp_dout);
    strobe();
    check_vec("R7 next strobe copies", exp_dout);

    // R9: sample 32 wraps to position 0
    sparse_load(33, 32, 6'b000001); strobe();
    check_vec("R9 wrap to index 0", 192'b1);

    // R8: partial load, strobe restarts, new config taken at first sample
    sparse_load(32, 0, 6'h00); strobe();
    full_load(5, 5); strobe();
    check_vec("R8 partial six-lane load", exp_dout);
    sparse_load(32, 0, 6'h00); sparse_load(5, 0, 6'h00); strobe();
    cfg_drv = 2'b01; dir_drv = 1'b1;
    sparse_load(1, 0, 6'b000001); strobe();
    check_vec("R8 restart with new cfg", (192'b1 << 189));

    // R1: reset in the middle of operation
    cfg_drv = 2'b00; dir_drv = 1'b0;
    full_load(9, 32); strobe();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    exp_col = '0; exp_dout = '0; m_cnt = 0;
    @(negedge clk);
    check_vec("R1 reset clears latch", '0);
    strobe();
    check_vec("R1 reset clears column register", '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule